// File: doc/BRIEF.md
# Selectable Odd-Ratio Clock Divider

This block takes a fast input clock and produces a sub-rate clock at one third or one fifth of its frequency, picked at run time by a single select input, with a true and a complement output. An odd ratio cannot reach an even duty cycle from one clock edge alone. The block therefore builds a phase signal on rising edges and a copy of that phase delayed by half an input period on falling edges. It combines the two so that the high and low times are each exactly N/2 input periods.

Three controls shape the output. An active-low master reset drives the output low at once, with no clock edge needed, and is released in step with the clock. An output enable is sampled on a rising edge and applied on the following falling edge. A clock-validity flag, already synchronous to the input clock, parks the divider in a quiet state whenever the input is judged unusable, so the output cannot toggle erratically. A new ratio takes effect only at the start of a fresh output period.

Top module: `odd_ratio_clk_div`

## Requirements
- R1: With select low (0), the true output is high for exactly 3 input half-periods and low for exactly 3 input half-periods, repeating.
- R2: With select high (1), the true output is high for exactly 5 input half-periods and low for exactly 5 input half-periods, repeating.
- R3: The complement output is always the logical inverse of the true output.
- R4: While the master reset input is low, the true output is 0 and the complement output is 1, and this takes hold at once when reset falls, with no clock edge needed.
- R5: After reset is released, internal logic leaves reset at the second rising edge. The first output period starts at the third rising edge, and with enable and validity high the true output first rises at the falling edge that follows that third rising edge.
- R6: The enable input is sampled on each rising edge and the sampled value takes effect at the next falling edge. While the applied enable is 0 the true output is 0.
- R7: The select input is sampled only at the rising edge that begins a new output period. A select change mid-period never shortens the current high or low phase.
- R8: When the validity flag is 0 at a rising edge, the divider returns to its idle state and the true output is 0 from that edge on. When the flag is 1 again at a rising edge, a fresh output period starts at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided; both edges are used |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| div_sel | input | 1 | Ratio select: 0 picks divide-by-3, 1 picks divide-by-5 |
| out_en | input | 1 | Output enable, applied after a rising then a falling edge |
| clk_valid | input | 1 | Input clock validity flag, synchronous to clk_in |
| q | output | 1 | Divided clock, true polarity |
| q_n | output | 1 | Divided clock, complement polarity |

## Verification
The embedded properties watch, on every cycle, that the period counter stays below the active ratio and that the latched ratio moves only at a period boundary. They also check that the output is low while the applied enable is low, for one cycle after an invalid-clock edge, and whenever reset is held. Exact high and low lengths in half-periods, the one-rise-one-fall latency of the enable, the start-up position after reset release, and an output forced low by reset in the middle of a high phase can only be shown by the bench's scenarios. The bench shows these by comparing against its edge-by-edge model and measuring pulse lengths.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic {
    RATIO_LO = 1'b0,
    RATIO_HI = 1'b1
  } ratio_e;

  function automatic int unsigned cnt_width(input int unsigned max_div);
    return (max_div < 2) ? 1 : $clog2(max_div);
  endfunction

endpackage

// File: rtl/odr_reset_sync.sv
module odr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/odr_period_counter.sv
module odr_period_counter
  import odr_pkg::*;
#(
  parameter int unsigned DIV_LO = 3,
  parameter int unsigned DIV_HI = 5,
  localparam int unsigned CW = cnt_width(DIV_HI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  output logic phase_hi
);

  localparam logic [CW-1:0] LAST_LO = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] MID_LO  = CW'((DIV_LO - 1) / 2);
  localparam logic [CW-1:0] MID_HI  = CW'((DIV_HI - 1) / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  ratio_e        ratio_q, ratio_d;
  logic          phase_q, phase_d;
  logic [CW-1:0] cnt_dec;
  logic [CW-1:0] mid_cur;

  assign cnt_dec = cnt_q - 1'b1;
  assign mid_cur = (ratio_q == RATIO_HI) ? MID_HI : MID_LO;

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (cnt_q == '0) begin
      ratio_d = sel ? RATIO_HI : RATIO_LO;
      cnt_d   = sel ? LAST_HI : LAST_LO;
      phase_d = 1'b1;
    end else begin
      cnt_d   = cnt_dec;
      phase_d = (cnt_dec >= mid_cur);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_LO;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      phase_q <= phase_d;
    end
  end

  assign phase_hi = phase_q;

  // R1 and R2: the count never leaves the range of the active ratio
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ((ratio_q == RATIO_HI) ? LAST_HI : LAST_LO));

  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(ratio_q));

endmodule

// File: rtl/odr_edge_shaper.sv
module odr_edge_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_hi,
  input  logic en_req,
  output logic shaped
);

  logic en_rise_q;
  logic en_fall_q;
  logic lag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_rise_q <= 1'b0;
    end else begin
      en_rise_q <= en_req;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_fall_q <= 1'b0;
      lag_q     <= 1'b0;
    end else begin
      en_fall_q <= en_rise_q;
      lag_q     <= phase_hi;
    end
  end

  assign shaped = phase_hi & lag_q & en_fall_q;

  p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_fall_q |-> !shaped);

endmodule

// File: rtl/odd_ratio_clk_div.sv
module odd_ratio_clk_div
  import odr_pkg::*;
#(
  parameter int unsigned DIV_LO    = 3,
  parameter int unsigned DIV_HI    = 5,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic div_sel,
  input  logic out_en,
  input  logic clk_valid,
  output logic q,
  output logic q_n
);

  logic rst_core_n;
  logic phase_hi;
  logic shaped;

  odr_reset_sync #(
    .STAGES(RST_SYNC)
  ) u_rst (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  odr_period_counter #(
    .DIV_LO(DIV_LO),
    .DIV_HI(DIV_HI)
  ) u_cnt (
    .clk     (clk_in),
    .rst_n   (rst_core_n),
    .run     (clk_valid),
    .sel     (div_sel),
    .phase_hi(phase_hi)
  );

  odr_edge_shaper u_shape (
    .clk     (clk_in),
    .rst_n   (rst_core_n),
    .phase_hi(phase_hi),
    .en_req  (out_en),
    .shaped  (shaped)
  );

  assign q   = shaped;
  assign q_n = ~shaped;

  // R4: output held low for every edge seen while reset is low
  always @(posedge clk_in) begin
    if (rst_n == 1'b0) begin
      p_reset_forces_r4: assert (q == 1'b0 && q_n == 1'b1);
    end
  end

  p_park_low_r8: assert property (@(posedge clk_in) disable iff (!rst_core_n)
    !clk_valid |=> !q);

endmodule

// File: tb/tb_odd_ratio_clk_div.sv
module tb_odd_ratio_clk_div;

  logic clk_in;
  logic rst_n;
  logic div_sel;
  logic out_en;
  logic clk_valid;
  logic q;
  logic q_n;

  int n_chk;
  int n_bad;
  bit done;
  string cur_req;

  // behavioural model state
  int  m_s1, m_s2;
  int  m_pos;
  int  m_len;
  bit  m_high, m_lag, m_enr, m_enf;
  bit  m_exp;

  odd_ratio_clk_div dut (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .out_en   (out_en),
    .clk_valid(clk_valid),
    .q        (q),
    .q_n      (q_n)
  );

  initial clk_in = 1'b0;
  always #4 clk_in = ~clk_in;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_s1 = 0; m_s2 = 0; m_pos = -1; m_len = 3;
    m_high = 0; m_lag = 0; m_enr = 0; m_enf = 0;
  endtask

  task automatic compare_now();
    m_exp = m_high & m_lag & m_enf;
    check(q === m_exp, cur_req, "q vs model", int'(q), int'(m_exp));
    check(q_n === ~m_exp, "R3", "q_n vs model", int'(q_n), int'(~m_exp));
  endtask

  // edge-by-edge reference model
  initial begin
    model_clear();
    forever begin
      @(posedge clk_in);
      if (!rst_n) begin
        model_clear();
      end else begin
        if (m_s2 != 0) begin
          m_enr = out_en;
          if (!clk_valid) begin
            m_pos  = -1;
            m_high = 0;
          end else begin
            if (m_pos < 0 || m_pos == m_len - 1) begin
              m_len = div_sel ? 5 : 3;
              m_pos = 0;
            end else begin
              m_pos++;
            end
            m_high = (m_pos < (m_len + 1) / 2);
          end
        end
        m_s2 = m_s1;
        m_s1 = 1;
      end
      #1 if (!done) compare_now();
      @(negedge clk_in);
      if (!rst_n) begin
        model_clear();
      end else if (m_s2 != 0) begin
        m_lag = m_high;
        m_enf = m_enr;
      end
      #1 if (!done) compare_now();
    end
  end

  // move to 2 ns after the next falling edge
  task automatic to_drive_slot();
    @(negedge clk_in);
    #2;
  endtask

  task automatic measure_runs(input int exp_len, input string req);
    int run_len;
    int seen;
    bit prev;
    bit started;
    run_len = 0; seen = 0; started = 0;
    @(posedge clk_in); #1;
    prev = q;
    for (int i = 0; i < exp_len * 8; i++) begin
      if (i % 2 == 0) begin @(negedge clk_in); #1; end
      else begin @(posedge clk_in); #1; end
      if (q == prev) begin
        run_len++;
      end else begin
        if (started) begin
          check(run_len + 1 == exp_len, req, "phase length", run_len + 1, exp_len);
          seen++;
        end
        started = 1;
        run_len = 0;
        prev = q;
      end
    end
    check(seen >= 4, req, "phases measured", seen, 4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    cur_req = "R4";
    rst_n = 1'b0; div_sel = 1'b0; out_en = 1'b1; clk_valid = 1'b1;
    repeat (3) to_drive_slot();
    check(q == 1'b0 && q_n == 1'b1, "R4", "reset state q", int'(q), 0);

    // R5: release and start-up position
    cur_req = "R5";
    rst_n = 1'b1;
    @(posedge clk_in); #1 check(q == 1'b0, "R5", "q after edge 1", int'(q), 0);
    @(posedge clk_in); #1 check(q == 1'b0, "R5", "q after edge 2", int'(q), 0);
    @(posedge clk_in); #1 check(q == 1'b0, "R5", "q after edge 3", int'(q), 0);
    @(negedge clk_in); #1 check(q == 1'b1, "R5", "first rise", int'(q), 1);

    // R1: divide by three
    cur_req = "R1";
    measure_runs(3, "R1");

    // R7: select change in mid period, then divide by five
    cur_req = "R7";
    to_drive_slot();
    div_sel = 1'b1;
    repeat (12) to_drive_slot();
    cur_req = "R2";
    measure_runs(5, "R2");

    // R6: enable off and back on
    cur_req = "R6";
    to_drive_slot();
    out_en = 1'b0;
    @(posedge clk_in);
    @(negedge clk_in); #1;
    for (int i = 0; i < 20; i++) begin
      check(q == 1'b0, "R6", "q while disabled", int'(q), 0);
      @(negedge clk_in); #1;
    end
    #1 out_en = 1'b1;
    repeat (12) to_drive_slot();

    // R8: invalid clock flag parks the divider
    cur_req = "R8";
    clk_valid = 1'b0;
    @(posedge clk_in); #1;
    for (int i = 0; i < 10; i++) begin
      check(q == 1'b0, "R8", "q while invalid", int'(q), 0);
      @(posedge clk_in); #1;
    end
    to_drive_slot();
    clk_valid = 1'b1;
    repeat (14) to_drive_slot();

    // R4: reset in the middle of a high phase, seen before any edge
    cur_req = "R4";
    do begin @(posedge clk_in or negedge clk_in); #1; end while (q != 1'b1);
    #1 rst_n = 1'b0;
    #1 check(q == 1'b0 && q_n == 1'b1, "R4", "async reset mid-high", int'(q), 0);
    repeat (3) to_drive_slot();
    check(q == 1'b0, "R4", "q held in reset", int'(q), 0);

    // back to divide by three after release
    cur_req = "R5";
    div_sel = 1'b0;
    rst_n = 1'b1;
    repeat (4) to_drive_slot();
    cur_req = "R1";
    measure_runs(3, "R1");

    // R7: five to three while enabled
    cur_req = "R7";
    div_sel = 1'b1;
    repeat (9) to_drive_slot();
    div_sel = 1'b0;
    repeat (9) to_drive_slot();

    finish_run();
  end

endmodule